// File: doc/BRIEF.md
# Host Register Access Sequencer

This block sits behind a host link that has already turned pin activity into bytes. It receives a byte strobe together with separate start, single-stop and continuous-stop strobes. From these it builds register-file writes and reads, FIFO pushes and pops, and command pulses. The peripheral never starts traffic on its own. Every transaction opens with a start strobe, and the first word after it is either a command or an address.

A transaction may carry any number of commands and then, at most, one address word. The data bytes after that address are routed to the register file or to the FIFO window. In continuous mode the address advances after each byte. Three-byte-deep registers take three bytes at one address, least significant byte first. The FIFO window takes every byte at the same address. When the stream breaks the ordering rules, a sticky error flag is raised and the rest of the transaction is dropped.

Read data is captured from the register file or the FIFO one cycle after the read or pop strobe, and is returned on a valid/data pair.

Top module: `hostseq`

## Requirements
- R1: A word with bit 7 = 1 and bits 6:5 = 00, in word position, produces a one-cycle `cmd_stb` on the clock edge that samples it, with `cmd_code` = bits 4:0. At most one of `reg_wr`, `reg_rd`, `fifo_push`, `fifo_pop` and `cmd_stb` is high in any cycle.
- R2: A word with bit 7 = 0 is an address: bit 6 = 1 selects read and 0 selects write, bit 5 is the continuous flag, and bits 4:0 are the register index. In non-continuous mode only the first data byte is accepted. A second data byte is a violation.
- R3: In continuous mode on ordinary registers, the first data byte goes to the given index and each later byte goes to the previous index plus one.
- R4: Indices 0x12, 0x14, 0x15, 0x16 and 0x17 are deep. A continuous access to one of them issues three accesses at the same index with `reg_lane` 0, 1 and 2 (least significant byte first), then moves to the next index. Accesses to other registers use lane 0.
- R5: Index 0x1F is the FIFO window. In continuous mode each data byte produces `fifo_push` (write) or `fifo_pop` (read) with `reg_addr` = 0x1F, and the index does not advance.
- R6: `rd_valid` pulses one cycle after each `reg_rd` or `fifo_pop`. `rd_data` then holds `reg_rdata` or `fifo_rdata` as presented during the strobe cycle.
- R7: Within one transaction, a command may be followed by further commands and then by one address word. A word-position byte with bit 7 = 1 and bits 6:5 ≠ 00 counts as data after a command and is a violation.
- R8: A continuous-address transaction must end with the continuous stop. Non-continuous and command-only transactions must end with the single stop. A mismatch sets `err`.
- R9: A non-continuous address word that names a deep register or the FIFO window is a violation and causes no access.
- R10: Reaching a second deep register in one transaction is a violation. The first byte aimed at it causes no access.
- R11: After a violation, `err` is set and stays set until reset. All bytes up to the next start strobe are ignored.
- R12: Bytes and stop strobes that arrive outside a transaction cause no output activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe from the host link |
| in_byte | input | 8 | Received byte |
| in_start | input | 1 | Start condition strobe |
| in_stop_sgl | input | 1 | Single-mode stop strobe |
| in_stop_cont | input | 1 | Continuous-mode stop strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 5 | Register index (0x1F during FIFO access) |
| reg_lane | output | 2 | Byte lane within a deep register |
| wr_data | output | 8 | Write data for register or FIFO |
| reg_rdata | input | 8 | Register file read data for the current index and lane |
| fifo_push | output | 1 | FIFO push strobe |
| fifo_pop | output | 1 | FIFO pop strobe |
| fifo_rdata | input | 8 | FIFO head byte |
| cmd_stb | output | 1 | Command pulse |
| cmd_code | output | 5 | Command code |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data returned to the host |
| err | output | 1 | Sticky protocol violation flag |

## Verification
Random continuous write bursts over ordinary registers, each read back by a continuous read burst, show whether the index advances by exactly one per byte and whether reads come back in order. Directed streams then cover the remaining behaviour:
- Deep registers written and read lane by lane tell a correct least-significant-first lane order from a reversed or skipped lane.
- A burst that runs from a deep register into the next index shows whether the index advances after the third lane.
- A mixed command-then-address stream that runs into the FIFO window shows whether the index holds at the window.

Each violation (data after a command, stop mismatch, non-continuous deep or FIFO access, second deep register, extra non-continuous byte) is followed by bytes that would otherwise write a register. Checking that register shows both whether the error is flagged and whether the rest of the transaction is really dropped.

// File: rtl/hostseq_pkg.sv
package hostseq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WORD = 2'd1,
    SQ_DATA = 2'd2,
    SQ_SKIP = 2'd3
  } sq_state_t;

  localparam int LOOKUPS = 3;
endpackage

// File: rtl/hostseq_word_dec.sv
module hostseq_word_dec #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic [DW-1:0] word,
  output logic          is_cmd,
  output logic          is_bad,
  output logic          is_read,
  output logic          is_cont,
  output logic [AW-1:0] idx
);
  // top bit: command flag; next two: read / continuous (must be zero in a command)
  assign is_cmd  = word[DW-1] && (word[DW-2:DW-3] == 2'b00);
  assign is_bad  = word[DW-1] && (word[DW-2:DW-3] != 2'b00);
  assign is_read = word[DW-2];
  assign is_cont = word[DW-3];
  assign idx     = word[AW-1:0];
endmodule

// File: rtl/hostseq_region.sv
module hostseq_region #(
  parameter int                   AW        = 5,
  parameter logic [(1<<AW)-1:0]   DEEP_MAP  = 32'h00F4_0000,
  parameter int                   FIFO_ADDR = 31
) (
  input  logic [AW-1:0] addr,
  output logic          deep,
  output logic          fifo
);
  assign deep = DEEP_MAP[addr];
  assign fifo = (addr == AW'(FIFO_ADDR));
endmodule

// File: rtl/hostseq_rdret.sv
module hostseq_rdret #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_req,
  input  logic          fifo_req,
  input  logic [DW-1:0] reg_rdata,
  input  logic [DW-1:0] fifo_rdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= reg_req | fifo_req;
      if (fifo_req)     rd_data <= fifo_rdata;
      else if (reg_req) rd_data <= reg_rdata;
    end
  end
endmodule

// File: rtl/hostseq_ctrl.sv
module hostseq_ctrl
  import hostseq_pkg::*;
#(
  parameter int                 AW        = 5,
  parameter int                 DW        = 8,
  parameter int                 LANES     = 3,
  parameter int                 LW        = 2,
  parameter logic [(1<<AW)-1:0] DEEP_MAP  = 32'h00F4_0000,
  parameter int                 FIFO_ADDR = 31
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_byte,
  input  logic          in_start,
  input  logic          in_stop_sgl,
  input  logic          in_stop_cont,
  input  logic          w_cmd,
  input  logic          w_bad,
  input  logic          w_rd,
  input  logic          w_cont,
  input  logic [AW-1:0] w_idx,
  output logic          reg_wr,
  output logic          reg_rd,
  output logic [AW-1:0] reg_addr,
  output logic [LW-1:0] reg_lane,
  output logic [DW-1:0] wr_data,
  output logic          fifo_push,
  output logic          fifo_pop,
  output logic          cmd_stb,
  output logic [AW-1:0] cmd_code,
  output logic          err
);
  localparam logic [LW-1:0] LAST_LANE = LW'(LANES - 1);

  sq_state_t     state;
  logic [AW-1:0] cur_addr;
  logic [LW-1:0] lane;
  logic          rd_mode, cont_mode, got_data, deep_used, blocked;

  // lookups: 0 = incoming word index, 1 = cursor, 2 = cursor + 1
  logic [AW-1:0]        look_a [LOOKUPS];
  logic [LOOKUPS-1:0]   look_deep, look_fifo;
  logic                 unused_next_fifo;

  assign look_a[0] = w_idx;
  assign look_a[1] = cur_addr;
  assign look_a[2] = AW'(cur_addr + 1'b1);
  assign unused_next_fifo = look_fifo[2];

  for (genvar g = 0; g < LOOKUPS; g++) begin : g_look
    hostseq_region #(.AW(AW), .DEEP_MAP(DEEP_MAP), .FIFO_ADDR(FIFO_ADDR)) u_region (
      .addr(look_a[g]), .deep(look_deep[g]), .fifo(look_fifo[g])
    );
  end

  logic any_stop;
  assign any_stop = in_stop_sgl | in_stop_cont;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      cur_addr  <= '0;
      lane      <= '0;
      rd_mode   <= 1'b0;
      cont_mode <= 1'b0;
      got_data  <= 1'b0;
      deep_used <= 1'b0;
      blocked   <= 1'b0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_addr  <= '0;
      reg_lane  <= '0;
      wr_data   <= '0;
      fifo_push <= 1'b0;
      fifo_pop  <= 1'b0;
      cmd_stb   <= 1'b0;
      cmd_code  <= '0;
      err       <= 1'b0;
    end else begin
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      fifo_push <= 1'b0;
      fifo_pop  <= 1'b0;
      cmd_stb   <= 1'b0;
      if (in_start) begin
        state     <= SQ_WORD;
        deep_used <= 1'b0;
        blocked   <= 1'b0;
      end else begin
        case (state)
          SQ_WORD: begin
            if (in_valid) begin
              if (w_bad) begin
                err   <= 1'b1;
                state <= SQ_SKIP;
              end else if (w_cmd) begin
                cmd_stb  <= 1'b1;
                cmd_code <= w_idx;
              end else if (!w_cont && (look_deep[0] || look_fifo[0])) begin
                err   <= 1'b1;
                state <= SQ_SKIP;
              end else begin
                cur_addr  <= w_idx;
                lane      <= '0;
                rd_mode   <= w_rd;
                cont_mode <= w_cont;
                got_data  <= 1'b0;
                deep_used <= look_deep[0];
                state     <= SQ_DATA;
              end
            end else if (in_stop_cont) begin
              err   <= 1'b1;
              state <= SQ_IDLE;
            end else if (in_stop_sgl) begin
              state <= SQ_IDLE;
            end
          end
          SQ_DATA: begin
            if (in_valid) begin
              if ((!cont_mode && got_data) || blocked) begin
                err   <= 1'b1;
                state <= SQ_SKIP;
              end else begin
                got_data <= 1'b1;
                reg_addr <= cur_addr;
                reg_lane <= lane;
                wr_data  <= in_byte;
                if (look_fifo[1]) begin
                  fifo_push <= !rd_mode;
                  fifo_pop  <= rd_mode;
                end else begin
                  reg_wr <= !rd_mode;
                  reg_rd <= rd_mode;
                  if (look_deep[1] && lane != LAST_LANE) begin
                    lane <= lane + 1'b1;
                  end else begin
                    lane     <= '0;
                    cur_addr <= look_a[2];
                    if (look_deep[2]) begin
                      if (deep_used) blocked   <= 1'b1;
                      else           deep_used <= 1'b1;
                    end
                  end
                end
              end
            end else if (any_stop) begin
              if (in_stop_cont != cont_mode) err <= 1'b1;
              state <= SQ_IDLE;
            end
          end
          SQ_SKIP: if (any_stop) state <= SQ_IDLE;
          default: state <= SQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/hostseq.sv
module hostseq #(
  parameter int                 AW        = 5,
  parameter int                 DW        = 8,
  parameter int                 LANES     = 3,
  parameter logic [(1<<AW)-1:0] DEEP_MAP  = 32'h00F4_0000,
  parameter int                 FIFO_ADDR = 31,
  localparam int                LW        = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_byte,
  input  logic          in_start,
  input  logic          in_stop_sgl,
  input  logic          in_stop_cont,
  output logic          reg_wr,
  output logic          reg_rd,
  output logic [AW-1:0] reg_addr,
  output logic [LW-1:0] reg_lane,
  output logic [DW-1:0] wr_data,
  input  logic [DW-1:0] reg_rdata,
  output logic          fifo_push,
  output logic          fifo_pop,
  input  logic [DW-1:0] fifo_rdata,
  output logic          cmd_stb,
  output logic [AW-1:0] cmd_code,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          err
);
  logic          w_cmd, w_bad, w_rd, w_cont;
  logic [AW-1:0] w_idx;

  hostseq_word_dec #(.DW(DW), .AW(AW)) u_dec (
    .word(in_byte), .is_cmd(w_cmd), .is_bad(w_bad),
    .is_read(w_rd), .is_cont(w_cont), .idx(w_idx)
  );

  hostseq_ctrl #(
    .AW(AW), .DW(DW), .LANES(LANES), .LW(LW),
    .DEEP_MAP(DEEP_MAP), .FIFO_ADDR(FIFO_ADDR)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_byte(in_byte), .in_start(in_start),
    .in_stop_sgl(in_stop_sgl), .in_stop_cont(in_stop_cont),
    .w_cmd(w_cmd), .w_bad(w_bad), .w_rd(w_rd), .w_cont(w_cont), .w_idx(w_idx),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_lane(reg_lane),
    .wr_data(wr_data), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code), .err(err)
  );

  hostseq_rdret #(.DW(DW)) u_rdret (
    .clk(clk), .rst(rst),
    .reg_req(reg_rd), .fifo_req(fifo_pop),
    .reg_rdata(reg_rdata), .fifo_rdata(fifo_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/hostseq_chk.sv
module hostseq_chk #(
  parameter int                 AW        = 5,
  parameter int                 LW        = 2,
  parameter logic [(1<<AW)-1:0] DEEP_MAP  = 32'h00F4_0000,
  parameter int                 FIFO_ADDR = 31
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [AW-1:0] reg_addr,
  input logic [LW-1:0] reg_lane,
  input logic          fifo_push,
  input logic          fifo_pop,
  input logic          cmd_stb,
  input logic          rd_valid,
  input logic          err
);
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_wr, reg_rd, fifo_push, fifo_pop, cmd_stb})); // R1

  AST_ACT_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr || reg_rd || fifo_push || fifo_pop || cmd_stb) |-> $past(in_valid)); // R12

  AST_LANE_SHALLOW: assert property (@(posedge clk) disable iff (rst)
    ((reg_wr || reg_rd) && !DEEP_MAP[reg_addr]) |-> (reg_lane == '0)); // R4

  AST_FIFO_FIXED: assert property (@(posedge clk) disable iff (rst)
    (fifo_push || fifo_pop) |-> (reg_addr == AW'(FIFO_ADDR))); // R5

  AST_RD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (reg_rd || fifo_pop) |=> rd_valid); // R6

  AST_RD_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(reg_rd || fifo_pop)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R11
endmodule

bind hostseq hostseq_chk #(
  .AW(AW), .LW(LW), .DEEP_MAP(DEEP_MAP), .FIFO_ADDR(FIFO_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_lane(reg_lane),
  .fifo_push(fifo_push), .fifo_pop(fifo_pop), .cmd_stb(cmd_stb),
  .rd_valid(rd_valid), .err(err)
);

// File: tb/hostseq_tb.sv
`timescale 1ns/1ps
module hostseq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_start = 1'b0, in_stop_sgl = 1'b0, in_stop_cont = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic reg_wr, reg_rd, fifo_push, fifo_pop, cmd_stb, rd_valid, err;
  logic [4:0] reg_addr, cmd_code;
  logic [1:0] reg_lane;
  logic [7:0] wr_data, reg_rdata, fifo_rdata, rd_data;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  hostseq u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_start(in_start), .in_stop_sgl(in_stop_sgl), .in_stop_cont(in_stop_cont),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_lane(reg_lane),
    .wr_data(wr_data), .reg_rdata(reg_rdata), .fifo_push(fifo_push),
    .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata), .cmd_stb(cmd_stb),
    .cmd_code(cmd_code), .rd_valid(rd_valid), .rd_data(rd_data), .err(err)
  );

  // peripheral model: register file with lanes, FIFO, and read-return log
  logic [7:0] mem [0:31][0:3];
  logic [7:0] fbuf [0:63];
  logic [5:0] fw = 6'd0, fr = 6'd0;
  logic [7:0] rdq [0:511];
  int rdn = 0;

  assign reg_rdata  = mem[reg_addr][reg_lane];
  assign fifo_rdata = fbuf[fr];

  always @(posedge clk) begin
    if (reg_wr) mem[reg_addr][reg_lane] <= wr_data;
    if (fifo_push) begin fbuf[fw] <= wr_data; fw <= fw + 6'd1; end
    if (fifo_pop) fr <= fr + 6'd1;
    if (rd_valid) begin rdq[rdn[8:0]] <= rd_data; rdn <= rdn + 1; end
  end

  // snapshot of outputs after the edge that sampled the last input
  logic s_cmd, s_wr, s_rd, s_push, s_pop;
  logic [4:0] s_code, s_addr;
  logic [1:0] s_lane;
  logic [7:0] v [0:31];

  function automatic logic [7:0] aw(input bit rd, input bit cont, input int idx);
    return {1'b0, rd, cont, idx[4:0]};
  endfunction

  function automatic logic [7:0] cw(input int code);
    return {3'b100, code[4:0]};
  endfunction

  task automatic chkv(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic snap();
    s_cmd = cmd_stb; s_code = cmd_code; s_wr = reg_wr; s_rd = reg_rd;
    s_push = fifo_push; s_pop = fifo_pop; s_addr = reg_addr; s_lane = reg_lane;
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_byte = b;
    @(posedge clk); #1; snap(); in_valid = 1'b0;
  endtask

  // 0 = start, 1 = single stop, 2 = continuous stop
  task automatic strobe(input int k);
    @(negedge clk);
    in_start = (k == 0); in_stop_sgl = (k == 1); in_stop_cont = (k == 2);
    @(posedge clk); #1; snap();
    in_start = 1'b0; in_stop_sgl = 1'b0; in_stop_cont = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int r0;
    logic [7:0] keep;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chkv("reset err", err, 0);
    chkv("reset strobes", {reg_wr, reg_rd, fifo_push, fifo_pop, cmd_stb, rd_valid}, 0);

    // R12: stray byte outside a transaction
    put(cw(5));
    chkv("R12 stray byte no cmd", s_cmd, 0);
    strobe(2);
    chkv("R12 stray stop no err", err, 0);

    // R1: command stream
    strobe(0);
    put(cw(3));
    chkv("R1 cmd strobe", s_cmd, 1);
    chkv("R1 cmd code", s_code, 3);
    put(cw(17));
    chkv("R1 second cmd code", s_code, 17);
    strobe(1);
    chkv("R1 no err", err, 0);

    // R7 R3 R5: commands, then continuous write 0x1D,0x1E, then into FIFO
    strobe(0);
    put(cw(2)); put(cw(4));
    put(aw(0, 1, 29));
    put(8'h05);
    chkv("R3 first index", s_addr, 29);
    put(8'h9C);
    chkv("R3 incremented index", s_addr, 30);
    put(8'hA1);
    chkv("R5 push strobe", s_push, 1);
    put(8'hA2); put(8'hA3);
    chkv("R5 index held", s_addr, 31);
    strobe(2);
    settle();
    chkv("R3 mem 1D", mem[29][0], 8'h05);
    chkv("R3 mem 1E", mem[30][0], 8'h9C);
    chkv("R5 push count", fw, 3);
    chkv("R5 fifo head", fbuf[0], 8'hA1);
    chkv("R7 mixed stream ok", err, 0);

    // R5 R6: FIFO pop reads
    r0 = rdn;
    strobe(0); put(aw(1, 1, 31));
    for (int i = 0; i < 3; i++) put(8'h00);
    strobe(2); settle();
    chkv("R6 fifo read 0", rdq[r0], 8'hA1);
    chkv("R6 fifo read 1", rdq[r0+1], 8'hA2);
    chkv("R5 fifo read 2", rdq[r0+2], 8'hA3);

    // R2 R6: non-continuous read
    r0 = rdn;
    strobe(0); put(aw(1, 0, 29)); put(8'h00); strobe(1); settle();
    chkv("R2 single read", rdq[r0], 8'h05);
    chkv("R2 no err", err, 0);

    // R4: deep register write, lane order
    strobe(0); put(aw(0, 1, 20));
    put(8'h11); chkv("R4 lane0", s_lane, 0);
    put(8'h22); chkv("R4 lane1", s_lane, 1);
    put(8'h33); chkv("R4 lane2", s_lane, 2);
    chkv("R4 same index", s_addr, 20);
    strobe(2);
    r0 = rdn;
    strobe(0); put(aw(1, 1, 20));
    for (int i = 0; i < 3; i++) put(8'h00);
    strobe(2); settle();
    chkv("R4 read lsb", rdq[r0], 8'h11);
    chkv("R4 read mid", rdq[r0+1], 8'h22);
    chkv("R4 read msb", rdq[r0+2], 8'h33);

    // R4: deep register then the next plain index
    strobe(0); put(aw(0, 1, 18));
    put(8'h01); put(8'h02); put(8'h03); put(8'h44);
    chkv("R4 advance after deep", s_addr, 19);
    chkv("R4 advance lane", s_lane, 0);
    strobe(2); settle();
    chkv("R4 mem 13", mem[19][0], 8'h44);
    chkv("R4 mem 12 msb", mem[18][2], 8'h03);

    // R3: random continuous bursts over plain registers with readback
    for (int it = 0; it < 16; it++) begin
      int base = $urandom_range(0, 15);
      int len = $urandom_range(1, 18 - base);
      strobe(0); put(aw(0, 1, base));
      for (int i = 0; i < len; i++) begin
        v[i] = 8'($urandom);
        put(v[i]);
      end
      strobe(2);
      r0 = rdn;
      strobe(0); put(aw(1, 1, base));
      for (int i = 0; i < len; i++) put(8'h00);
      strobe(2); settle();
      for (int i = 0; i < len; i++) chkv("R3 burst readback", rdq[r0+i], v[i]);
    end
    chkv("R3 bursts no err", err, 0);

    // R10: second deep register in one stream
    keep = mem[21][0];
    strobe(0); put(aw(0, 1, 20));
    put(8'h51); put(8'h52); put(8'h53); put(8'h54);
    chkv("R10 no write", s_wr, 0);
    strobe(2); settle();
    chkv("R10 err", err, 1);
    chkv("R10 mem 15 kept", mem[21][0], keep);

    // R11: sticky and ignored until next start; next transaction still works
    keep = mem[5][0];
    strobe(0); put(cw(1)); put(8'hA5);
    chkv("R7 bad word no cmd", s_cmd, 0);
    put(aw(0, 0, 5)); put(8'h77);
    chkv("R11 ignored write", s_wr, 0);
    strobe(1); settle();
    chkv("R11 mem 05 kept", mem[5][0], keep);
    strobe(0); put(aw(0, 0, 6)); put(8'h66); strobe(1); settle();
    chkv("R11 later write", mem[6][0], 8'h66);
    chkv("R11 err sticky", err, 1);

    // R7: data after command
    do_reset();
    chkv("R7 reset clears err", err, 0);
    strobe(0); put(cw(1)); put(8'hC0); strobe(1); settle();
    chkv("R7 bad word err", err, 1);

    // R9: non-continuous deep and FIFO
    do_reset();
    keep = mem[22][0];
    strobe(0); put(aw(0, 0, 22)); put(8'hEE);
    chkv("R9 no deep write", s_wr, 0);
    strobe(1); settle();
    chkv("R9 err deep", err, 1);
    chkv("R9 mem 16 kept", mem[22][0], keep);
    do_reset();
    strobe(0); put(aw(0, 0, 31)); put(8'hEE);
    chkv("R9 no push", s_push, 0);
    strobe(1); settle();
    chkv("R9 err fifo", err, 1);

    // R8: stop mismatch
    do_reset();
    strobe(0); put(aw(0, 1, 3)); put(8'h3C); strobe(1); settle();
    chkv("R8 cont ended single", err, 1);
    do_reset();
    strobe(0); put(aw(0, 0, 3)); put(8'h3D); strobe(2); settle();
    chkv("R8 single ended cont", err, 1);

    // R2: extra byte in non-continuous mode
    do_reset();
    keep = mem[8][0];
    strobe(0); put(aw(0, 0, 7)); put(8'h70); put(8'h71);
    chkv("R2 extra byte no write", s_wr, 0);
    strobe(1); settle();
    chkv("R2 extra byte err", err, 1);
    chkv("R2 mem 08 kept", mem[8][0], keep);
    chkv("R2 first byte written", mem[7][0], 8'h70);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule